// File: doc/BRIEF.md
# Buffered Modulus Timebase Counter

This block is a timer channel that produces a shared time base. Its counter runs between a fixed floor of one and a programmable ceiling. It can count up only, or up and then back down. The ceiling is double-buffered: software writes a staging register at any time, and the active ceiling takes that value only on the tick that brings the count back to one. A period can therefore be retimed mid-cycle without a short or stretched cycle.

The counter advances once per system clock, or on selected edges of an external pin. The external pin passes through a synchroniser and an edge detector inside the block. A sticky cycle flag marks every return to one and is cleared by a write-one strobe. The count value and the current direction are driven out so that neighbouring channels can use them as their time base.

The buffer write port is a plain register write. It always accepts data, and it has no back-pressure. Every other pin is level or strobe control.

Top module: `btb_top`

## Requirements
- R1: After reset the count is 1, the direction output is 0 (up) and the flag is 0. Both the active ceiling and the staging register hold 2.
- R2: With the mode enabled and up-only selected (`updown_i`=0), each tick raises the count by one. The tick after the count equals the active ceiling sets the count to 1, so a cycle lasts "ceiling" ticks.
- R3: The active ceiling is loaded from the staging register only on the tick that brings the count to 1. The load uses the staging value held before that clock edge. A write in the same cycle as the boundary therefore takes effect one cycle later.
- R4: With up/down selected (`updown_i`=1), the count reverses at the ceiling and counts down. `dir_down_o` is 1 while the count descends. When the count reaches 1 the direction returns to up, so a cycle lasts 2×ceiling−2 ticks.
- R5: If the count is above the active ceiling while counting up, it passes the ceiling without matching. It runs to all-ones and the next tick sets it to 1, which counts as a cycle boundary.
- R6: When `ext_clk_sel_i`=1, ticks come only from external pin edges. `edge_sel_i` selects the edge: 0 = rising, 1 = falling, 2 or 3 = both. The count changes on the third rising system-clock edge after the pin change.
- R7: While `mode_en_i`=0, the count and the direction hold. A buffer write is copied into both the staging register and the active ceiling in the same cycle.
- R8: The flag is set on every cycle boundary and stays set until `flag_clr_i` is 1 at a clock edge. If a set and a clear fall in the same cycle, the set wins.
- R9: With the mode enabled and up-only selected, `dir_down_o` is 0 from the next clock onward.
- R10: The count is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_en_i | input | 1 | Counting enabled when 1 |
| updown_i | input | 1 | 0 = up-only, 1 = up/down |
| ext_clk_sel_i | input | 1 | 0 = tick every clock, 1 = tick on external pin edges |
| ext_pin_i | input | 1 | Asynchronous external clock pin |
| edge_sel_i | input | 2 | Qualifying pin edge: 0 rising, 1 falling, 2/3 both |
| buf_wr_i | input | 1 | Write strobe for the staging ceiling register |
| buf_data_i | input | CNT_W | Ceiling value to write (legal values are 2 or more) |
| flag_clr_i | input | 1 | Write-one-to-clear for the cycle flag |
| count_o | output | CNT_W | Counter value for the time-base bus |
| flag_o | output | 1 | Sticky cycle-boundary flag |
| dir_down_o | output | 1 | 1 while counting down |

## Verification
The hardest state to reach from the ports is a count above the active ceiling, because in normal running the ceiling reloads only when the count is 1. The bench builds the count up under a large ceiling and then disables the mode. While the mode is off, a buffer write moves straight into the ceiling, so the bench writes a small value there and re-enables counting. The count then has to climb to all-ones and wrap. The bench instantiates the block with a 10-bit counter so that this run stays short. Random phases then mix ceiling rewrites near the boundary, direction changes, external-pin edges of each kind and flag clears that collide with flag sets.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/btb_edge_qual.sv
module btb_edge_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       pulse_o
);
  import btb_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  edge_mode_e             mode;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i) begin
      if (!rst_ni)     sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= pin_i;
      else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  always_comb begin
    mode = edge_mode_e'(edge_sel_i);
    unique case (mode)
      EDGE_RISE: pulse_o = cur & ~prev_q;
      EDGE_FALL: pulse_o = ~cur & prev_q;
      default:   pulse_o = cur ^ prev_q;
    endcase
  end
endmodule

// File: rtl/btb_count_core.sv
module btb_count_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             updown_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_down_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO    = CNT_W'(2);
  localparam logic [CNT_W-1:0] ALL_1S = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, ceil_q, ceil_d, stage_q, stage_d;
  logic             dir_q, dir_d, flag_q, flag_d, boundary;

  always_comb begin
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    ceil_d   = ceil_q;
    stage_d  = wr_i ? wr_data_i : stage_q;
    boundary = 1'b0;
    if (!en_i) begin
      ceil_d = stage_d;
    end else begin
      if (tick_i) begin
        if (updown_i && dir_q) begin
          cnt_d = cnt_q - ONE;
        end else if (cnt_q == ceil_q) begin
          cnt_d = updown_i ? (cnt_q - ONE) : ONE;
          if (updown_i) dir_d = 1'b1;
        end else if (cnt_q == ALL_1S) begin
          cnt_d = ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
        boundary = (cnt_d == ONE);
      end
      if (boundary) begin
        dir_d  = 1'b0;
        ceil_d = stage_q;
      end
      if (!updown_i) dir_d = 1'b0;
    end
    if (boundary)   flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q   <= ONE;
      dir_q   <= 1'b0;
      flag_q  <= 1'b0;
      ceil_q  <= TWO;
      stage_q <= TWO;
    end else begin
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      flag_q  <= flag_d;
      ceil_q  <= ceil_d;
      stage_q <= stage_d;
    end
  end

  assign count_o    = cnt_q;
  assign dir_down_o = dir_q;
  assign flag_o     = flag_q;
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_en_i,
  input  logic             updown_i,
  input  logic             ext_clk_sel_i,
  input  logic             ext_pin_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             buf_wr_i,
  input  logic [CNT_W-1:0] buf_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             dir_down_o
);
  logic pin_pulse, tick;

  btb_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .edge_sel_i (edge_sel_i),
    .pulse_o    (pin_pulse)
  );

  assign tick = ext_clk_sel_i ? pin_pulse : 1'b1;

  btb_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mode_en_i),
    .tick_i     (tick),
    .updown_i   (updown_i),
    .wr_i       (buf_wr_i),
    .wr_data_i  (buf_data_i),
    .clr_i      (flag_clr_i),
    .count_o    (count_o),
    .dir_down_o (dir_down_o),
    .flag_o     (flag_o)
  );
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_en_i,
  input logic             updown_i,
  input logic             ext_clk_sel_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             flag_o,
  input logic             dir_down_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_COUNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o != '0); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> ($stable(count_o) && $stable(dir_down_o))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R8
  AST_FLAG_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> (count_o == ONE)); // R3
  AST_UPONLY_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && !updown_i) |=> !dir_down_o); // R9
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_en_i && !updown_i && !ext_clk_sel_i) |=>
      (count_o == ONE || count_o == $past(count_o) + ONE)); // R2
endmodule

bind btb_top btb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_en_i     (mode_en_i),
  .updown_i      (updown_i),
  .ext_clk_sel_i (ext_clk_sel_i),
  .flag_clr_i    (flag_clr_i),
  .count_o       (count_o),
  .flag_o        (flag_o),
  .dir_down_o    (dir_down_o)
);

// File: tb/btb_top_tb.sv
module btb_top_tb;
  localparam int W = 10;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, ud = 0, xs = 0, pin = 0, wr = 0, clr = 0;
  logic [1:0] es = 0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] count;
  logic flag, dirdn;

  int nvec = 0, nbad = 0;
  string tag = "R2";
  bit done = 0;

  // reference state
  logic [W-1:0] m_cnt, m_a1, m_a2;
  logic m_dir, m_flag, m_s1, m_s2, m_p;

  always #4 clk = ~clk;

  btb_top #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_en_i(en), .updown_i(ud),
    .ext_clk_sel_i(xs), .ext_pin_i(pin), .edge_sel_i(es),
    .buf_wr_i(wr), .buf_data_i(wd), .flag_clr_i(clr),
    .count_o(count), .flag_o(flag), .dir_down_o(dirdn)
  );

  function automatic logic edge_hit(logic s, logic p, logic [1:0] sel);
    if (sel == 2'd0) return s & ~p;
    if (sel == 2'd1) return ~s & p;
    return s ^ p;
  endfunction

  function automatic logic [W-1:0] next_up(logic [W-1:0] c, logic [W-1:0] a1,
                                           logic updn, logic down);
    if (updn && down) return c - 1;
    if (c == a1)      return updn ? c - 1 : W'(1);
    if (c == MAXV)    return W'(1);
    return c + 1;
  endfunction

  task automatic model_step();
    logic tick, bnd;
    logic [W-1:0] a2n;
    tick = en && (!xs || edge_hit(m_s2, m_p, es));
    bnd = 0;
    a2n = wr ? wd : m_a2;
    if (!en) begin
      m_a1 = a2n;
    end else begin
      if (tick) begin
        if (!(ud && m_dir) && ud && m_cnt == m_a1) m_dir = 1;
        m_cnt = next_up(m_cnt, m_a1, ud, m_dir && !(m_cnt == m_a1 && !m_dir));
        bnd = (m_cnt == W'(1));
      end
      if (bnd) begin m_dir = 0; m_a1 = m_a2; end
      if (!ud) m_dir = 0;
    end
    m_a2 = a2n;
    if (bnd) m_flag = 1; else if (clr) m_flag = 0;
    m_p = m_s2; m_s2 = m_s1; m_s1 = pin;
  endtask

  task automatic check(string t, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    check({tag, " count"}, count, m_cnt);
    check({tag, " dir"}, dirdn, m_dir);
    check({tag, " flag"}, flag, m_flag);
    check("R10 nonzero", int'(count != 0), 1);
    wr = 0; clr = 0;
  endtask

  task automatic wait_one();
    for (int k = 0; k < 3000 && !(count == 1); k++) cyc();
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cnt = 1; m_a1 = 2; m_a2 = 2; m_dir = 0; m_flag = 0;
    m_s1 = 0; m_s2 = 0; m_p = 0;
    check("R1 count", count, 1);
    check("R1 dir", dirdn, 0);
    check("R1 flag", flag, 0);

    // R1: reset ceiling of 2 gives 1,2,1,2
    tag = "R1"; en = 1;
    for (int i = 0; i < 6; i++) cyc();

    // R2 directed: ceiling 5, up-only
    tag = "R2"; wr = 1; wd = 5; cyc();
    for (int i = 0; i < 20; i++) cyc();

    // R3: write on the boundary cycle itself
    tag = "R3";
    wait_one();
    for (int i = 0; i < 4; i++) cyc();
    wr = 1; wd = 3; cyc();
    for (int i = 0; i < 15; i++) cyc();

    // R4: up/down with ceiling 6
    tag = "R4"; ud = 1; wr = 1; wd = 6; cyc();
    for (int i = 0; i < 40; i++) cyc();
    wr = 1; wd = 2; cyc();
    for (int i = 0; i < 20; i++) cyc();

    // R5: count above ceiling through an idle write
    tag = "R5"; ud = 0; wr = 1; wd = 60; cyc();
    wait_one();
    for (int i = 0; i < 49; i++) cyc();
    tag = "R7"; en = 0;
    for (int i = 0; i < 5; i++) cyc();
    wr = 1; wd = 10; cyc();
    cyc();
    tag = "R5"; en = 1;
    for (int i = 0; i < 1100; i++) cyc();
    ud = 1; wr = 1; wd = 40; cyc();
    wait_one();
    for (int i = 0; i < 45; i++) cyc();
    en = 0; wr = 1; wd = 4; cyc();
    en = 1;
    for (int i = 0; i < 1100; i++) cyc();

    // R8: clears, including collisions with sets
    tag = "R8"; ud = 0; wr = 1; wd = 4; cyc();
    for (int i = 0; i < 60; i++) begin
      clr = ($urandom % 2) == 1;
      cyc();
    end

    // R6: external pin, each edge mode
    tag = "R6"; xs = 1;
    for (int m = 0; m < 4; m++) begin
      es = 2'(m);
      for (int i = 0; i < 120; i++) begin
        if ($urandom % 3 == 0) pin = ~pin;
        ud = (i > 60);
        cyc();
      end
    end
    xs = 0;

    // R9: leave up/down while descending
    tag = "R9"; ud = 1; wr = 1; wd = 9; cyc();
    wait_one();
    for (int i = 0; i < 11; i++) cyc();
    ud = 0;
    for (int i = 0; i < 12; i++) cyc();

    // constrained random mix
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      en  = ($urandom % 10) != 0;
      if ($urandom % 50 == 0) ud = ~ud;
      if ($urandom % 80 == 0) xs = ~xs;
      if ($urandom % 4 == 0) pin = ~pin;
      es  = 2'($urandom % 4);
      wr  = ($urandom % 12) == 0;
      wd  = W'(2 + ($urandom % 14));
      clr = ($urandom % 6) == 0;
      tag = !en ? "R7" : xs ? "R6" : ud ? "R4" : "R2";
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule